// File: doc/BRIEF.md
# Dual-Channel Serial DAC Load Controller

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. It runs on a fast system clock. It receives 16-bit words over a three-wire serial link made of an active-low frame sync, a serial clock and a data line. Each word carries a channel-select bit and a 12-bit code. The block writes that code into the input register of channel A or channel B.

A shared active-low load strobe copies both input registers into the two output latches at once. If the load strobe is held low, the latches follow each completed word automatically. An active-low clear input forces both latches to the zero-output code of the current data format. With the format input high, incoming codes are twos complement and are converted to the offset-binary latch encoding.

All four control pins and the data line are resynchronized through a flop chain. Their edges are then detected in the system clock domain, so the serial clock must be much slower than the system clock.

Top module: `dual_dac_loader`

## Requirements
- R1: After synchronous reset (rst_n low at a rising clock edge), code_a and code_b are both 0x000.
- R2: While fsync_n is low, sdin is sampled on each falling edge of sclk, most significant bit first. Word bit 12 selects the channel (0 = A, 1 = B) and bits 11..0 are the code. Bits 15..13 have no effect.
- R3: While load_n stays high, a completed word changes only an input register, and code_a and code_b keep their values.
- R4: A falling edge on load_n copies both input registers into both latches in the same cycle.
- R5: While load_n is held low, both latches take the input register values as soon as the sixteenth falling sclk edge of a frame completes a word, and not before.
- R6: A frame in which fsync_n rises before sixteen sclk falling edges leaves both input registers unchanged.
- R7: Falling sclk edges after the sixteenth in one frame are ignored until fsync_n rises.
- R8: With twos_comp high, bit 11 of each incoming code is inverted before it is stored (0x7FF becomes 0xFFF, 0x800 becomes 0x000). With twos_comp low, the code is stored as received.
- R9: While clear_n is low, both latches hold 0x800 if twos_comp is high and 0x000 otherwise, whatever load_n and the serial link do.
- R10: fsync_n high returns the bit counter to zero, so a full frame that follows a short frame is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data, MSB first |
| fsync_n | input | 1 | Active-low frame sync |
| load_n | input | 1 | Active-low load strobe; held low selects automatic update |
| clear_n | input | 1 | Active-low clear of both latches |
| twos_comp | input | 1 | Data format: 1 = twos complement, 0 = straight/offset binary (quasi-static) |
| code_a | output | 12 | Latch code of channel A |
| code_b | output | 12 | Latch code of channel B |

## Verification
The bench builds the block with its defaults: a 12-bit code, a 16-bit frame and a two-flop synchronizer. This gives the real frame layout, including the channel bit at position 12 and three ignored leading bits. The twos-complement corners 0x7FF, 0x800 and 0x001 sit right at the bit-11 inversion. Short and over-long frames (10 and 20 clock edges) exercise the counter at both sides of the sixteenth edge. In automatic-update mode, the outputs are observed after the fifteenth edge and again after the sixteenth.

// File: rtl/dacfe_pkg.sv
// Package: shared types for the dual DAC load controller.
// Assumes exactly two channels, addressed by one select bit.
package dacfe_pkg;
    localparam int NUM_CH = 2;
    typedef enum logic {CH_A = 1'b0, CH_B = 1'b1} chan_e;
endpackage

// File: rtl/pin_sync.sv
// Module: pin_sync
// Resynchronizes a vector of asynchronous pins through STAGES flops and
// also keeps one extra delayed copy, so callers can detect edges.
// Assumes each pin is stable for several system clocks between changes.
module pin_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dprev
);
    logic [STAGES:0][W-1:0] stg_q;

    // Shift the pins through the synchronizer chain plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= {(STAGES+1){RST_VAL}};
        end else begin
            stg_q[0] <= din;
            for (int s = 1; s <= STAGES; s++) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign dout  = stg_q[STAGES-1];
    assign dprev = stg_q[STAGES];
endmodule

// File: rtl/serial_rx.sv
// Module: serial_rx
// Collects one FRAME_W-bit word per frame, MSB first, on falling serial
// clock edges while frame sync is low. It flags a word only on the last bit.
// Extra edges are ignored, and frame sync high clears the count.
// Assumes inputs are already synchronized to clk.
module serial_rx #(
    parameter int FRAME_W = 16,
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fs_s,
    input  logic               sclk_fall,
    input  logic               sdin_s,
    output logic               word_valid,
    output logic [FRAME_W-1:0] word,
    output logic [CNT_W-1:0]   bit_cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    logic [FRAME_W-2:0] sh_q;

    // Count and shift bits inside a frame; idle frame sync rearms the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sh_q    <= '0;
        end else if (fs_s) begin
            bit_cnt <= '0;
        end else if (sclk_fall && bit_cnt < FULL) begin
            sh_q    <= {sh_q[FRAME_W-3:0], sdin_s};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Present the completed word during the cycle of its final bit.
    always_comb begin
        word_valid = !fs_s && sclk_fall && (bit_cnt == LAST);
        word       = {sh_q, sdin_s};
    end
endmodule

// File: rtl/dac_regs.sv
// Module: dac_regs
// Holds one input register and one output latch per channel. It handles
// format conversion, load-strobe and automatic updates, and clear.
// Assumes twos_comp is static during operation.
module dac_regs
    import dacfe_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  chan_e                          wr_ch,
    input  logic [CODE_W-1:0]              wr_code,
    input  logic                           twos_comp,
    input  logic                           ld_fall,
    input  logic                           ld_s,
    input  logic                           clr_s,
    output logic [NUM_CH-1:0][CODE_W-1:0]  lat
);
    localparam logic [CODE_W-1:0] MSB_MASK = CODE_W'(1) << (CODE_W - 1);

    logic [CODE_W-1:0] code_in;
    logic [CODE_W-1:0] clr_code;
    logic              upd;

    // Convert the incoming code and choose the clear code for the format.
    always_comb begin
        code_in  = twos_comp ? (wr_code ^ MSB_MASK) : wr_code;
        clr_code = twos_comp ? MSB_MASK : '0;
        upd      = ld_fall || (wr_en && !ld_s);
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [CODE_W-1:0] in_q, in_nx, lat_q;

        // Next input register value: the new code if this channel is addressed.
        always_comb begin
            in_nx = (wr_en && wr_ch == chan_e'(1'(ch))) ? code_in : in_q;
        end

        // Input register update.
        always_ff @(posedge clk) begin
            if (!rst_n) in_q <= '0;
            else        in_q <= in_nx;
        end

        // Output latch: clear dominates, then a load or automatic update.
        always_ff @(posedge clk) begin
            if (!rst_n)      lat_q <= '0;
            else if (!clr_s) lat_q <= clr_code;
            else if (upd)    lat_q <= in_nx;
        end

        assign lat[ch] = lat_q;
    end
endmodule

// File: rtl/dual_dac_loader.sv
// Module: dual_dac_loader (top)
// Serial front end of a two-channel DAC. It synchronizes the pins, detects
// edges, receives words, and drives two latch codes.
// Assumes the system clock is at least eight times the serial clock rate.
module dual_dac_loader
    import dacfe_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int FRAME_W     = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              fsync_n,
    input  logic              load_n,
    input  logic              clear_n,
    input  logic              twos_comp,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b
);
    logic [4:0] pins_s, pins_p;
    logic sclk_s, sclk_p, sdin_s, fs_s, ld_s, ld_p, clr_s;
    logic sclk_fall, ld_fall;
    logic word_valid;
    logic [FRAME_W-1:0] word;
    logic [CNT_W-1:0] bit_cnt;
    logic [NUM_CH-1:0][CODE_W-1:0] lat;

    pin_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11111)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({sclk, sdin, fsync_n, load_n, clear_n}),
        .dout(pins_s), .dprev(pins_p)
    );

    // Split the synchronized pins and find the falling edges.
    always_comb begin
        {sclk_s, sdin_s, fs_s, ld_s, clr_s} = pins_s;
        sclk_p    = pins_p[4];
        ld_p      = pins_p[1];
        sclk_fall = sclk_p && !sclk_s;
        ld_fall   = ld_p && !ld_s;
    end

    serial_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .fs_s(fs_s), .sclk_fall(sclk_fall),
        .sdin_s(sdin_s), .word_valid(word_valid), .word(word), .bit_cnt(bit_cnt)
    );

    dac_regs #(.CODE_W(CODE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(word_valid),
        .wr_ch(chan_e'(word[CODE_W])), .wr_code(word[CODE_W-1:0]),
        .twos_comp(twos_comp), .ld_fall(ld_fall), .ld_s(ld_s), .clr_s(clr_s),
        .lat(lat)
    );

    assign code_a = lat[CH_A];
    assign code_b = lat[CH_B];
endmodule

// File: rtl/dual_dac_loader_chk.sv
// Module: dual_dac_loader_chk
// Assertion checker bound into dual_dac_loader.
module dual_dac_loader_chk #(
    parameter int CODE_W  = 12,
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              twos_comp,
    input logic              clr_s,
    input logic              fs_s,
    input logic              ld_fall,
    input logic              ld_s,
    input logic              word_valid,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [CODE_W-1:0] code_a,
    input logic [CODE_W-1:0] code_b
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (code_a == '0 && code_b == '0));

    assert_hold_no_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s && !ld_fall && !(word_valid && !ld_s)) |=> ($stable(code_a) && $stable(code_b)));

    assert_word_at_last_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> (bit_cnt == CNT_W'(FRAME_W)));

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_W));

    assert_clear_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> (code_a == ($past(twos_comp) ? MID : '0) &&
                    code_b == ($past(twos_comp) ? MID : '0)));

    assert_fs_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fs_s |=> (bit_cnt == '0));
endmodule

bind dual_dac_loader dual_dac_loader_chk #(
    .CODE_W(CODE_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .twos_comp(twos_comp), .clr_s(clr_s),
    .fs_s(fs_s), .ld_fall(ld_fall), .ld_s(ld_s), .word_valid(word_valid),
    .bit_cnt(bit_cnt), .code_a(code_a), .code_b(code_b)
);

// File: tb/dual_dac_loader_bench.sv
module dual_dac_loader_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, sdin = 1'b0, fsync_n = 1'b1;
    logic load_n = 1'b1, clear_n = 1'b1, twos_comp = 1'b0;
    logic [11:0] code_a, code_b;

    int checks = 0;
    int errors = 0;
    int pushed = 0;
    int popped = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [11:0] a;
        logic [11:0] b;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    // Reference model state, kept from the requirements.
    logic [11:0] m_in_a = '0, m_in_b = '0, m_lat_a = '0, m_lat_b = '0;

    always #4 clk = ~clk;

    dual_dac_loader u_dual_dac_loader (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .fsync_n(fsync_n),
        .load_n(load_n), .clear_n(clear_n), .twos_comp(twos_comp),
        .code_a(code_a), .code_b(code_b)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Push an expected output pair and wait until the monitor has compared it.
    task automatic expect_out(input logic [11:0] a, input logic [11:0] b, input string tag);
        exp_t e;
        e.a = a; e.b = b; e.tag = tag;
        exp_q.push_back(e);
        pushed++;
        wait (popped == pushed);
    endtask

    // Drive bits first..first+n-1 of a frame; bits past 15 are driven as 1.
    task automatic send_bits(input logic [15:0] w, input int first, input int n,
                             input bit close_frame);
        fsync_n = 1'b0;
        wait_clk(4);
        for (int i = first; i < first + n; i++) begin
            sdin = (i < 16) ? w[15-i] : 1'b1;
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(4);
            sclk = 1'b1;
        end
        wait_clk(4);
        if (close_frame) begin
            fsync_n = 1'b1;
            wait_clk(6);
        end
    endtask

    function automatic logic [11:0] conv(input logic [11:0] c);
        return twos_comp ? (c ^ 12'h800) : c;
    endfunction

    // Full frame: model the input register write and any automatic update.
    task automatic frame(input logic [2:0] dc, input bit ch, input logic [11:0] code);
        send_bits({dc, ch, code}, 0, 16, 1'b1);
        if (ch) m_in_b = conv(code); else m_in_a = conv(code);
        if (!load_n && clear_n) begin m_lat_a = m_in_a; m_lat_b = m_in_b; end
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wait_clk(4);
        load_n = 1'b1;
        wait_clk(4);
        if (clear_n) begin m_lat_a = m_in_a; m_lat_b = m_in_b; end
    endtask

    // Monitor: compare each expected item against the outputs away from the edge.
    initial begin
        exp_t e;
        forever begin
            wait (exp_q.size() > 0);
            repeat (6) @(negedge clk);
            e = exp_q.pop_front();
            checks++;
            if (code_a !== e.a || code_b !== e.b) begin
                errors++;
                $display("FAIL %s: actual a=%h b=%h expected a=%h b=%h",
                         e.tag, code_a, code_b, e.a, e.b);
            end
            popped++;
        end
    end

    // Watchdog.
    initial begin
        wait_clk(100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        expect_out(12'h000, 12'h000, "R1 reset state");

        frame(3'b000, 1'b0, 12'h123);
        expect_out(m_lat_a, m_lat_b, "R3 no change without load");
        expect_out(12'h000, 12'h000, "R3 literal hold");
        pulse_load();
        expect_out(12'h123, 12'h000, "R4 load A");

        frame(3'b111, 1'b1, 12'hABC);
        pulse_load();
        expect_out(12'h123, 12'hABC, "R2 channel B, dont-care bits set");

        frame(3'b101, 1'b1, 12'h555);
        expect_out(12'h123, 12'hABC, "R3 B written, latches hold");
        frame(3'b010, 1'b0, 12'h0F0);
        pulse_load();
        expect_out(12'h0F0, 12'h555, "R4 both latches together");

        send_bits({3'b000, 1'b0, 12'hFFF}, 0, 10, 1'b1);
        pulse_load();
        expect_out(12'h0F0, 12'h555, "R6 short frame discarded");

        frame(3'b000, 1'b0, 12'h321);
        pulse_load();
        expect_out(12'h321, 12'h555, "R10 full frame after short one");

        send_bits({3'b000, 1'b0, 12'h246}, 0, 20, 1'b1);
        m_in_a = 12'h246;
        pulse_load();
        expect_out(12'h246, 12'h555, "R7 extra edges ignored");

        load_n = 1'b0;
        wait_clk(6);
        send_bits({3'b000, 1'b0, 12'h456}, 0, 15, 1'b0);
        expect_out(12'h246, 12'h555, "R5 no update after 15 edges");
        send_bits({3'b000, 1'b0, 12'h456}, 15, 1, 1'b1);
        m_in_a = 12'h456; m_lat_a = 12'h456;
        expect_out(12'h456, 12'h555, "R5 auto update on 16th edge");
        frame(3'b000, 1'b1, 12'h9AB);
        expect_out(12'h456, 12'h9AB, "R5 auto update channel B");

        twos_comp = 1'b1;
        wait_clk(2);
        frame(3'b000, 1'b0, 12'h7FF);
        expect_out(12'hFFF, 12'h9AB, "R8 0x7FF converted");
        frame(3'b000, 1'b1, 12'h800);
        expect_out(12'hFFF, 12'h000, "R8 0x800 converted");
        frame(3'b000, 1'b0, 12'h001);
        expect_out(12'h801, 12'h000, "R8 0x001 converted");

        clear_n = 1'b0;
        wait_clk(6);
        expect_out(12'h800, 12'h800, "R9 clear twos complement");
        frame(3'b000, 1'b1, 12'h100);
        expect_out(12'h800, 12'h800, "R9 clear dominates auto update");
        clear_n = 1'b1;
        wait_clk(6);
        load_n = 1'b1;
        wait_clk(6);
        twos_comp = 1'b0;
        clear_n = 1'b0;
        wait_clk(6);
        expect_out(12'h000, 12'h000, "R9 clear binary");
        pulse_load();
        expect_out(12'h000, 12'h000, "R9 load while clear held");
        clear_n = 1'b1;
        wait_clk(6);
        pulse_load();
        expect_out(12'h801, 12'h900, "R4 load after clear released");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule